// File: doc/BRIEF.md
# Command-Driven Audio Bit-Depth Reducer

This block lowers the resolution of a stereo audio stream. Each left/right sample pair arrives together on one strobe and leaves one cycle later with every bit below a chosen number of most significant bits forced to zero. The number of kept bits runs from 1 to 16. It is picked by single ASCII characters that arrive on a byte-wide strobe, typically straight from a serial receiver. Bytes that are not valid commands are dropped.

A digit or a letter, in either case, is folded into one code from 1 to 16. The keep mask is then made by shifting a lone sign bit arithmetically right, so the sign copies fill the top of the word. Each accepted command raises a one-cycle strobe and presents the selected count, so that a separate status printer can report it. A new mask applies starting with the next sample pair, so the two channels of one pair never see different masks.

Top module: `bitdepth_trim`

## Requirements
- R1: After reset the keep mask is all ones, so a sample pair passes unchanged; `sel_valid` and `out_valid` are 0 and `sel_bits` is 0.
- R2: The bytes 0x31 to 0x39 ('1' to '9') select 1 to 9 kept bits.
- R3: The bytes 0x41 to 0x47 ('A' to 'G') select 10 to 16 kept bits.
- R4: The bytes 0x61 to 0x67 ('a' to 'g') are first reduced by 0x20 and then act exactly as 'A' to 'G'.
- R5: For a selection of N, the mask is 0x800000 shifted arithmetically right by N-1, which leaves exactly the top N of the 24 bits set.
- R6: Any other byte, such as '0', ':', '@', 'H', '`', 'h' or a byte with bit 7 set, leaves the mask and `sel_bits` unchanged and raises no `sel_valid`.
- R7: For a pair presented with `smp_valid` high, `out_valid` is high one cycle later and `out_left` and `out_right` equal the inputs ANDed with the same mask. `out_valid` is low in any cycle that follows a cycle without `smp_valid`.
- R8: A command and a sample pair in the same cycle: the pair uses the previous mask, and the next pair uses the new one.
- R9: An accepted command raises `sel_valid` for exactly the following cycle with `sel_bits` = N. `sel_bits` keeps that value until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | ASCII command byte |
| smp_valid | input | 1 | Sample pair strobe |
| smp_left | input | 24 | Left channel sample |
| smp_right | input | 24 | Right channel sample |
| out_valid | output | 1 | Processed pair strobe |
| out_left | output | 24 | Masked left sample |
| out_right | output | 24 | Masked right sample |
| sel_valid | output | 1 | One-cycle pulse on an accepted command |
| sel_bits | output | 5 | Number of kept bits last selected |

## Verification
A table steps through the boundary characters of each accepted range and the bytes just outside them ('0', ':', '@', 'H', '`', 'h', 0xB1). Each command is followed by a sample pair whose two channels hold different bit patterns. In this way a wrong range edge, a wrong case fold or a leak from an ignored byte shows up as a wrong mask on both channels. Directed cases put a command and a sample in the same cycle to confirm which mask applies at the pair boundary. They also send two commands back to back to show that the strobe stays high on consecutive commands and that the count is held afterwards.

// File: rtl/bdt_pkg.sv
package bdt_pkg;

    localparam logic [7:0] CH_DIGIT_LO  = 8'h31;
    localparam logic [7:0] CH_DIGIT_HI  = 8'h39;
    localparam logic [7:0] CH_UPPER_LO  = 8'h41;
    localparam logic [7:0] CH_UPPER_HI  = 8'h47;
    localparam logic [7:0] CH_LOWER_LO  = 8'h61;
    localparam logic [7:0] CH_LOWER_HI  = 8'h67;
    localparam logic [7:0] CASE_OFFSET  = 8'h20;
    localparam logic [7:0] DIGIT_BASE   = 8'h30;
    localparam logic [7:0] LETTER_BASE  = 8'h37;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/bdt_cmd_decode.sv
module bdt_cmd_decode
    import bdt_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic [7:0]        ch,
    output logic              hit,
    output logic [CODE_W-1:0] bits
);

    logic [7:0] folded;

    always_comb begin
        // lowercase letters collapse onto uppercase before range checks
        folded = ch;
        if (ch >= CH_LOWER_LO && ch <= CH_LOWER_HI) begin
            folded = ch - CASE_OFFSET;
        end
        hit  = 1'b0;
        bits = '0;
        if (folded >= CH_DIGIT_LO && folded <= CH_DIGIT_HI) begin
            hit  = 1'b1;
            bits = CODE_W'(folded - DIGIT_BASE);
        end else if (folded >= CH_UPPER_LO && folded <= CH_UPPER_HI) begin
            hit  = 1'b1;
            bits = CODE_W'(folded - LETTER_BASE);
        end
    end

endmodule

// File: rtl/bdt_mask_gen.sv
module bdt_mask_gen #(
    parameter int DATA_W = 24,
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] keep,
    output logic [DATA_W-1:0] mask
);

    localparam logic signed [DATA_W-1:0] SEED = {1'b1, {(DATA_W-1){1'b0}}};

    logic [CODE_W-1:0] shamt;

    always_comb begin
        shamt = keep - CODE_W'(1);
        // sign copies fill the word from the top as the seed moves right
        mask  = $unsigned(SEED >>> shamt);
    end

endmodule

// File: rtl/bdt_lane.sv
module bdt_lane #(
    parameter int DATA_W = 24
) (
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] dout
);

    always_comb begin
        dout = din & mask;
    end

endmodule

// File: rtl/bitdepth_trim.sv
module bitdepth_trim
    import bdt_pkg::*;
#(
    parameter  int DATA_W   = 24,
    parameter  int MAX_BITS = 16,
    localparam int CODE_W   = $clog2(MAX_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_left,
    input  logic [DATA_W-1:0] smp_right,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic              sel_valid,
    output logic [CODE_W-1:0] sel_bits
);

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [CODE_W-1:0] bits;
        logic              sel_vld;
        logic              out_vld;
        logic [DATA_W-1:0] out_l;
        logic [DATA_W-1:0] out_r;
    } state_t;

    state_t st_d, st_q;

    logic              cmd_hit;
    logic [CODE_W-1:0] cmd_bits;
    logic [DATA_W-1:0] new_mask;
    logic [DATA_W-1:0] mask_q;

    logic [DATA_W-1:0] lane_in  [NUM_CH];
    logic [DATA_W-1:0] lane_out [NUM_CH];

    bdt_cmd_decode #(.CODE_W(CODE_W)) decode_i (
        .ch   (cmd_byte),
        .hit  (cmd_hit),
        .bits (cmd_bits)
    );

    bdt_mask_gen #(.DATA_W(DATA_W), .CODE_W(CODE_W)) maskgen_i (
        .keep (cmd_bits),
        .mask (new_mask)
    );

    assign lane_in[0] = smp_left;
    assign lane_in[1] = smp_right;
    assign mask_q     = st_q.mask;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        bdt_lane #(.DATA_W(DATA_W)) lane_i (
            .din  (lane_in[g]),
            .mask (st_q.mask),
            .dout (lane_out[g])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.sel_vld = 1'b0;
        st_d.out_vld = smp_valid;
        // the pair in this cycle uses the mask held before any command here
        if (smp_valid) begin
            st_d.out_l = lane_out[0];
            st_d.out_r = lane_out[1];
        end
        if (cmd_valid && cmd_hit) begin
            st_d.mask    = new_mask;
            st_d.bits    = cmd_bits;
            st_d.sel_vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask    <= '1;
            st_q.bits    <= '0;
            st_q.sel_vld <= 1'b0;
            st_q.out_vld <= 1'b0;
            st_q.out_l   <= '0;
            st_q.out_r   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_vld;
    assign out_left  = st_q.out_l;
    assign out_right = st_q.out_r;
    assign sel_valid = st_q.sel_vld;
    assign sel_bits  = st_q.bits;

endmodule

// File: rtl/bdt_checks.sv
module bdt_checks #(
    parameter int DATA_W = 24,
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              smp_valid,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_left,
    input logic [DATA_W-1:0] out_right,
    input logic              sel_valid,
    input logic [CODE_W-1:0] sel_bits,
    input logic [DATA_W-1:0] mask_q
);

    // R5: mask is a contiguous run of ones from the top bit
    a_r5_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[DATA_W-1] && (((mask_q << 1) & ~mask_q) == '0));

    // R7: both outputs are cleared below the mask held when the pair entered
    a_r7_same_mask: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (((out_left | out_right) & ~$past(mask_q)) == '0));

    // R7: output strobe follows the input strobe by one cycle
    a_r7_out_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(smp_valid));

    // R6: without a command strobe the mask and count hold
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(mask_q) && $stable(sel_bits) && !sel_valid));

    // R9: selection pulse carries a legal count
    a_r9_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (sel_bits >= CODE_W'(1) && sel_bits <= CODE_W'(16)));

endmodule

bind bitdepth_trim bdt_checks #(.DATA_W(DATA_W), .CODE_W(CODE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .smp_valid (smp_valid),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .sel_valid (sel_valid),
    .sel_bits  (sel_bits),
    .mask_q    (mask_q)
);

// File: tb/bitdepth_trim_tb_top.sv
module bitdepth_trim_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_left = '0;
    logic [23:0] smp_right = '0;
    logic        out_valid;
    logic [23:0] out_left;
    logic [23:0] out_right;
    logic        sel_valid;
    logic [4:0]  sel_bits;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    bitdepth_trim dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .smp_valid (smp_valid),
        .smp_left  (smp_left),
        .smp_right (smp_right),
        .out_valid (out_valid),
        .out_left  (out_left),
        .out_right (out_right),
        .sel_valid (sel_valid),
        .sel_bits  (sel_bits)
    );

    // {byte, expected kept bits; 0 = ignored}
    localparam logic [12:0] TBL [20] = '{
        {8'h31, 5'd1},  {8'h39, 5'd9},  {8'h35, 5'd5},  {8'h30, 5'd0},
        {8'h41, 5'd10}, {8'h47, 5'd16}, {8'h63, 5'd12}, {8'h48, 5'd0},
        {8'h3A, 5'd0},  {8'h40, 5'd0},  {8'h67, 5'd16}, {8'h61, 5'd10},
        {8'h68, 5'd0},  {8'h60, 5'd0},  {8'hB1, 5'd0},  {8'h32, 5'd2},
        {8'h46, 5'd15}, {8'h65, 5'd14}, {8'h37, 5'd7},  {8'h44, 5'd13}
    };

    function automatic logic [23:0] top_ones(input int n);
        return (n == 0) ? 24'hFFFFFF : ~(24'hFFFFFF >> n);
    endfunction

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_pair(input logic [23:0] l, input logic [23:0] r);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_left  = l;
        smp_right = r;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R7 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [23:0] cur_mask;
        logic [4:0]  cur_bits;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sel_valid", {23'd0, sel_valid}, 24'd0);
        chk("R1 out_valid", {23'd0, out_valid}, 24'd0);
        chk("R1 sel_bits", {19'd0, sel_bits}, 24'd0);
        rst_n = 1'b1;
        send_pair(24'h9ABCDE, 24'h13579B);
        chk("R1 out_valid", {23'd0, out_valid}, 24'd1);
        chk("R1 left passthrough", out_left, 24'h9ABCDE);
        chk("R1 right passthrough", out_right, 24'h13579B);
        @(negedge clk);
        chk("R7 out_valid idle", {23'd0, out_valid}, 24'd0);

        cur_mask = 24'hFFFFFF;
        cur_bits = 5'd0;
        // R2 R3 R4 R5 R6 R7 R9 table walk
        for (int i = 0; i < 20; i++) begin
            logic [7:0]  c;
            logic [4:0]  n;
            logic [23:0] l;
            logic [23:0] r;
            c = TBL[i][12:5];
            n = TBL[i][4:0];
            send_cmd(c);
            if (n != 0) begin
                cur_mask = top_ones(int'(n));
                cur_bits = n;
            end
            chk("R9/R6 sel_valid", {23'd0, sel_valid}, {23'd0, (n != 0)});
            chk("R2/R3/R4/R6 sel_bits", {19'd0, sel_bits}, {19'd0, cur_bits});
            l = 24'hA5C3F7 ^ (24'(i) * 24'h13579);
            r = ~l;
            send_pair(l, r);
            chk("R5/R7 left", out_left, l & cur_mask);
            chk("R5/R7 right", out_right, r & cur_mask);
        end

        // R8: command and pair in the same cycle
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = 8'h33;
        smp_valid = 1'b1;
        smp_left  = 24'hFFFFFF;
        smp_right = 24'h7FFFFF;
        @(negedge clk);
        cmd_valid = 1'b0;
        smp_valid = 1'b0;
        chk("R8 old mask left", out_left, 24'hFFFFFF & cur_mask);
        chk("R8 old mask right", out_right, 24'h7FFFFF & cur_mask);
        chk("R9 sel_bits", {19'd0, sel_bits}, 24'd3);
        send_pair(24'hFFFFFF, 24'h7FFFFF);
        chk("R8 new mask left", out_left, 24'hE00000);
        chk("R8 new mask right", out_right, 24'h600000);

        // R9: back-to-back commands, then the pulse ends and the count holds
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = 8'h34;
        @(negedge clk);
        cmd_byte  = 8'h62;
        chk("R9 first pulse", {23'd0, sel_valid}, 24'd1);
        chk("R9 first count", {19'd0, sel_bits}, 24'd4);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9 second pulse", {23'd0, sel_valid}, 24'd1);
        chk("R4 second count", {19'd0, sel_bits}, 24'd11);
        @(negedge clk);
        chk("R9 pulse ends", {23'd0, sel_valid}, 24'd0);
        chk("R9 count held", {19'd0, sel_bits}, 24'd11);
        send_pair(24'h123456, 24'hFEDCBA);
        chk("R5 left 11 bits", out_left, 24'h123456 & 24'hFFE000);
        chk("R5 right 11 bits", out_right, 24'hFEDCBA & 24'hFFE000);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule